// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protect Controller

This block is the command front end of a 2K x 8 serial EEPROM on an SPI link in mode 0. It watches the chip-select, serial clock and serial data input pins and assembles 8-bit opcodes while chip-select is low. It supports four commands: a status read, a status write, write-enable and write-disable. It also holds the 8-bit status register. Bit 7 is the write-protect-enable flag, bits 3:2 are the block-protect code, bit 1 is the write enable latch, bit 0 is the write-busy flag, and bits 6:4 always read as zero.

The array data path lives outside this block. It asks for permission here before it writes. The block combines the block-protect code, the write enable latch, the write-protect-enable flag and the `wp_n` pin. From these it reports whether the presented array address may be written and whether the status register may be written. An accepted write starts an internal write cycle that lasts a fixed number of clock cycles, modelled by a counter. While that cycle runs, every command except the status read is ignored. When the cycle ends, the enable latch clears.

The SPI pins are taken into the `clk` domain through synchronisers, so the serial clock must run well below `clk`. A half period of at least `SYNC_STAGES + 3` clock cycles is enough. The array request port is valid/ready. The data path holds `arr_req_valid` and `arr_req_addr` until `arr_req_ready` is high. Ready is low during a write cycle and in the cycle a status write starts. A request accepted at a permitted address starts a write cycle. An accepted request at a forbidden address is dropped and changes no state.

Top module: `ee_stat_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 when `NV_INIT` is 0. `wr_busy` and `spi_so_oe` are 0 and `arr_req_ready` is 1.
- R2: Status read, opcode 0x05, is accepted at any time, including during a write cycle. The byte is `{wpen,3'b000,bp1,bp0,wel,wip}`. It is shifted out MSB first, and `spi_so` changes after each falling SCK that follows the eighth opcode bit. The byte repeats while SCK keeps toggling.
- R3: Opcode 0x06 sets the write enable latch and opcode 0x04 clears it. Each takes effect when chip-select rises after exactly 8 bits, whatever the protection state.
- R4: Status write, opcode 0x01 followed by a data byte, with exactly 16 bits and `sts_wr_ok` high, copies data bits 7, 3 and 2 into the register and starts a write cycle. The other data bits are discarded.
- R5: `arr_wr_ok` is 1 only when the latch is set and `arr_req_addr` is outside the protected range. The ranges are: code 0 protects nothing, code 1 protects 0x600 to 0x7FF, code 2 protects 0x400 to 0x7FF, and code 3 protects the whole array.
- R6: `sts_wr_ok` is 1 only when the latch is set and it is not the case that write-protect-enable is 1 and `wp_n` is 0. A status write attempted while `sts_wr_ok` is 0 changes nothing.
- R7: A write cycle holds `wr_busy` and the busy status bit at 1 for exactly `WR_CYCLES` clock cycles. Both fall together, and the latch clears at that same time.
- R8: During a write cycle, status writes, write-enable and write-disable are ignored and the cycle runs to completion.
- R9: `arr_req_ready` is 0 during a write cycle. A handshake with `arr_wr_ok` high starts a write cycle. A handshake with `arr_wr_ok` low leaves the status unchanged.
- R10: A frame whose bit count differs from its command's length (8, or 16 for a status write) is ignored.
- R11: `spi_so_oe` is 0 while chip-select is high and during the opcode bits. It is 1 from the first data bit of a status read until chip-select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_si | input | 1 | Serial data in, sampled on rising SCK |
| spi_so | output | 1 | Serial data out, changes on falling SCK |
| spi_so_oe | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| wp_n | input | 1 | Write-protect pin, active low |
| arr_req_valid | input | 1 | Array write request valid |
| arr_req_ready | output | 1 | Array write request ready |
| arr_req_addr | input | ADDR_W | Array address being written or queried |
| arr_wr_ok | output | 1 | Address in `arr_req_addr` may be written now |
| sts_wr_ok | output | 1 | Status register may be written now |
| wr_busy | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the block with `ADDR_W = 11`, `SYNC_STAGES = 2` and `WR_CYCLES = 600`. This write time is longer than a full 16-bit status frame, so commands can be issued and observed while a write cycle is still running, and the busy window can be counted to the exact cycle. With the 11-bit address space, the bench sweeps every block-protect code, both write-protect-enable values, both latch values and both `wp_n` levels over sixteen addresses. The sixteen addresses include each segment boundary. The expected permissions are computed arithmetically in the bench.

// File: rtl/ee_stat_pkg.sv
`timescale 1ns/1ps
package ee_stat_pkg;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;

  localparam int unsigned LEN_SHORT = 8;
  localparam int unsigned LEN_WRSR  = 16;

  localparam logic [7:0] MSK_WPEN = 8'h80;
  localparam logic [7:0] MSK_BP1  = 8'h08;
  localparam logic [7:0] MSK_BP0  = 8'h04;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;

  function automatic logic [7:0] stat_byte(input stat_t s);
    return {s.wpen, 3'b000, s.bp, s.wel, s.wip};
  endfunction
endpackage

// File: rtl/ee_spi_rx.sv
`timescale 1ns/1ps
module ee_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             si,
  output logic             sel,
  output logic             sck_fall,
  output logic             frame_end,
  output logic             opc_stb,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [7:0]       wdata
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_OP  = CNT_W'(7);
  localparam logic [CNT_W-1:0] CNT_DAT = CNT_W'(15);

  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, si_sy;
  logic sck_s, cs_s, si_s, sck_d, cs_d, sck_rise;
  logic [6:0] sh;

  // synchroniser chains; chip-select resets to idle (high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      cs_sy  <= '1;
      si_sy  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      cs_sy  <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      si_sy  <= {si_sy[SYNC_STAGES-2:0], si};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  assign sck_s     = sck_sy[SYNC_STAGES-1];
  assign cs_s      = cs_sy[SYNC_STAGES-1];
  assign si_s      = si_sy[SYNC_STAGES-1];
  assign sel       = !cs_s;
  assign sck_rise  = sel && sck_s && !sck_d;
  assign sck_fall  = sel && !sck_s && sck_d;
  assign frame_end = cs_s && !cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      opcode  <= '0;
      wdata   <= '0;
      opc_stb <= 1'b0;
    end else begin
      opc_stb <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh <= {sh[5:0], si_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_OP) begin
          opcode  <= {sh, si_s};
          opc_stb <= 1'b1;
        end
        if (bit_cnt == CNT_DAT) wdata <= {sh, si_s};
      end
    end
  end

  AST_OPC_AT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    opc_stb |-> (bit_cnt == CNT_W'(8))); // R10
  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && $past(!sel)) |-> (bit_cnt == '0)); // R10
endmodule

// File: rtl/ee_wp_decode.sv
`timescale 1ns/1ps
module ee_wp_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bp,
  input  logic              wpen,
  input  logic              wel,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              arr_ok,
  output logic              sts_ok
);
  logic [1:0] seg;
  logic       prot;

  // array split into four equal segments by the two address MSBs
  assign seg = addr[ADDR_W-1 -: 2];

  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (seg == 2'b11);
      2'b10:   prot = seg[1];
      default: prot = 1'b1;
    endcase
  end

  assign arr_ok = wel && !prot;
  assign sts_ok = wel && !(wpen && !wp_n);
endmodule

// File: rtl/ee_wr_timer.sv
`timescale 1ns/1ps
module ee_wr_timer #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [TW-1:0] LOAD = TW'(WR_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= LOAD;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  AST_TMR_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
endmodule

// File: rtl/ee_stat_ctrl.sv
`timescale 1ns/1ps
module ee_stat_ctrl
  import ee_stat_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         WR_CYCLES   = 5000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] NV_INIT     = 3'b000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              spi_so,
  output logic              spi_so_oe,
  input  logic              wp_n,
  input  logic              arr_req_valid,
  output logic              arr_req_ready,
  input  logic [ADDR_W-1:0] arr_req_addr,
  output logic              arr_wr_ok,
  output logic              sts_wr_ok,
  output logic              wr_busy
);
  localparam int CNT_W = 5;

  logic             sel, sck_fall, frame_end, opc_stb;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode, wdata;
  logic             wpen_q, wel_q, wip;
  logic [1:0]       bp_q;
  logic             tmr_done, exec, sts_start, arr_acc, tmr_start;
  stat_t            st;
  logic [7:0]       tx_sh;
  logic [2:0]       tx_bit;
  logic             tx_on;

  ee_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .sel(sel), .sck_fall(sck_fall), .frame_end(frame_end), .opc_stb(opc_stb),
    .bit_cnt(bit_cnt), .opcode(opcode), .wdata(wdata)
  );

  ee_wp_decode #(.ADDR_W(ADDR_W)) wp_i (
    .bp(bp_q), .wpen(wpen_q), .wel(wel_q), .wp_n(wp_n), .addr(arr_req_addr),
    .arr_ok(arr_wr_ok), .sts_ok(sts_wr_ok)
  );

  ee_wr_timer #(.WR_CYCLES(WR_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(wip), .done(tmr_done)
  );

  assign st = '{wpen: wpen_q, bp: bp_q, wel: wel_q, wip: wip};

  // commands execute on chip-select rise, never while a cycle runs
  assign exec          = frame_end && !wip;
  assign sts_start     = exec && (bit_cnt == CNT_W'(LEN_WRSR)) && (opcode == OP_WRSR) && sts_wr_ok;
  assign arr_req_ready = !wip && !sts_start;
  assign arr_acc       = arr_req_valid && arr_req_ready && arr_wr_ok;
  assign tmr_start     = sts_start || arr_acc;
  assign wr_busy       = wip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen_q <= NV_INIT[2];
      bp_q   <= NV_INIT[1:0];
      wel_q  <= 1'b0;
    end else begin
      if (sts_start) begin
        wpen_q <= |(wdata & MSK_WPEN);
        bp_q   <= {|(wdata & MSK_BP1), |(wdata & MSK_BP0)};
      end
      if (tmr_done) begin
        wel_q <= 1'b0;
      end else if (exec && (bit_cnt == CNT_W'(LEN_SHORT))) begin
        if (opcode == OP_WREN)      wel_q <= 1'b1;
        else if (opcode == OP_WRDI) wel_q <= 1'b0;
      end
    end
  end

  // status read shifter: loads after the opcode, drives on falling SCK
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      tx_bit    <= '0;
      tx_on     <= 1'b0;
      spi_so    <= 1'b0;
      spi_so_oe <= 1'b0;
    end else if (!sel) begin
      tx_on     <= 1'b0;
      spi_so_oe <= 1'b0;
    end else if (opc_stb && (opcode == OP_RDSR)) begin
      tx_on  <= 1'b1;
      tx_sh  <= stat_byte(st);
      tx_bit <= '0;
    end else if (tx_on && sck_fall) begin
      spi_so    <= tx_sh[7];
      spi_so_oe <= 1'b1;
      tx_bit    <= tx_bit + 1'b1;
      if (tx_bit == 3'd7) tx_sh <= stat_byte(st);
      else                tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  AST_WIP_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(tmr_start)); // R7
  AST_WEL_CLR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel_q); // R7
  AST_NV_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> $stable({wpen_q, bp_q})); // R8
  AST_DROP_FORBIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req_valid && arr_req_ready && !arr_wr_ok) |=> !wip); // R9
  AST_WEL_SET_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(frame_end)); // R3
  AST_SO_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && $past(!sel)) |-> !spi_so_oe); // R11
endmodule

// File: tb/ee_stat_ctrl_tb_top.sv
`timescale 1ns/1ps
module ee_stat_ctrl_tb_top;
  localparam int ADDR_W = 11;
  localparam int WRC    = 600;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, rdy, a_ok, s_ok, busy;
  logic req_v = 1'b0;
  logic [ADDR_W-1:0] req_a = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ee_stat_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WRC), .SYNC_STAGES(2), .NV_INIT(3'b000)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe), .wp_n(wp_n), .arr_req_valid(req_v),
    .arr_req_ready(rdy), .arr_req_addr(req_a), .arr_wr_ok(a_ok),
    .sts_wr_ok(s_ok), .wr_busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] tx, input int n, output logic [15:0] rx, output logic [15:0] oem);
    rx = '0; oem = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      rx  = {rx[14:0], so};
      oem = {oem[14:0], so_oe};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1; si = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [15:0] r, m;
    xfer({16'h0, op}, 8, r, m);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [15:0] r, m;
    xfer({8'h0, 8'h01, v}, 16, r, m);
  endtask

  task automatic rdsr_chk(input logic [7:0] exp, input string req);
    logic [15:0] r, m;
    xfer({8'h0, 8'h05, 8'h00}, 16, r, m);
    chk(r[7:0] == exp, req, r[7:0], exp);
    chk(m == 16'h00FF, "R11 oe during frame", m, 16'h00FF);
    chk(so_oe == 1'b0, "R11 oe after cs high", so_oe, 0);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  task automatic arr_req(input logic [ADDR_W-1:0] a, input bit exp_rdy, input string req);
    @(negedge clk); req_v = 1'b1; req_a = a;
    #1 chk(rdy == exp_rdy, req, rdy, exp_rdy);
    @(negedge clk); req_v = 1'b0;
  endtask

  function automatic bit prot(input int bp, input int a);
    case (bp)
      0: return 1'b0;
      1: return a >= 16'h600;
      2: return a >= 16'h400;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [15:0] r, m;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(so_oe == 0, "R1 oe", so_oe, 0);
    chk(rdy == 1, "R1 ready", rdy, 1);
    rdsr_chk(8'h00, "R1 status");

    // R3 latch set/clear
    cmd(8'h06); rdsr_chk(8'h02, "R3 wren");
    cmd(8'h04); rdsr_chk(8'h00, "R3 wrdi");

    // R6 status write without latch is ignored
    wrsr(8'h8C);
    chk(busy == 0, "R6 no cycle", busy, 0);
    rdsr_chk(8'h00, "R6 no latch");

    // R4 masking, R2 read during busy
    cmd(8'h06); wrsr(8'hFF);
    chk(busy == 1, "R4 cycle started", busy, 1);
    rdsr_chk(8'h8F, "R2 read in cycle");
    wait_idle();
    rdsr_chk(8'h8C, "R4 masked bits");
    cmd(8'h06); wrsr(8'h00); wait_idle();

    // R10 wrong lengths
    xfer({15'h0, 8'h06, 1'b0}, 9, r, m);
    rdsr_chk(8'h00, "R10 nine-bit wren");
    cmd(8'h06);
    xfer({9'h0, 8'h01, 7'h7F}, 15, r, m);
    chk(busy == 0, "R10 short wrsr", busy, 0);
    xfer({8'h01, 8'h8C, 8'h00}, 24, r, m);
    chk(busy == 0, "R10 long wrsr", busy, 0);
    rdsr_chk(8'h02, "R10 status kept");

    // R7 exact duration, R9 ready low
    arr_req(11'h100, 1'b1, "R9 ready idle");
    cnt = 0;
    while (busy) begin
      if (cnt == 5) chk(rdy == 0, "R9 ready in cycle", rdy, 0);
      cnt++; @(negedge clk);
    end
    chk(cnt == WRC, "R7 cycle length", cnt, WRC);
    rdsr_chk(8'h00, "R7 latch cleared");

    // R8 commands ignored during cycle
    cmd(8'h06);
    arr_req(11'h000, 1'b1, "R9 accept");
    wrsr(8'h0C);
    cmd(8'h06);
    chk(busy == 1, "R8 cycle continues", busy, 1);
    wait_idle();
    rdsr_chk(8'h00, "R8 ignored in cycle");

    // R9 drops: no latch, then protected address
    arr_req(11'h000, 1'b1, "R9 ready no latch");
    chk(busy == 0, "R9 drop no latch", busy, 0);
    cmd(8'h06); wrsr(8'h04); wait_idle();
    cmd(8'h06);
    arr_req(11'h700, 1'b1, "R9 ready prot");
    chk(busy == 0, "R9 drop protected", busy, 0);
    rdsr_chk(8'h06, "R9 status unchanged");
    arr_req(11'h5FF, 1'b1, "R9 ready unprot");
    chk(busy == 1, "R9 accept unprot", busy, 1);
    wait_idle();

    // R5/R6 sweep
    for (int bp = 0; bp < 4; bp++) begin
      for (int we = 0; we < 2; we++) begin
        wp_n = 1'b1;
        cmd(8'h06); wrsr({we[0], 3'b000, bp[1:0], 2'b00}); wait_idle();
        rdsr_chk({we[0], 3'b000, bp[1:0], 2'b00}, "R4 sweep setup");
        for (int wl = 0; wl < 2; wl++) begin
          cmd(wl == 1 ? 8'h06 : 8'h04);
          rdsr_chk({we[0], 3'b000, bp[1:0], wl[0], 1'b0}, "R3 sweep latch");
          for (int wp = 0; wp < 2; wp++) begin
            wp_n = wp[0];
            for (int a = 0; a < 2048; a += 128) begin
              @(negedge clk); req_a = ADDR_W'(a);
              #1;
              chk(a_ok == (wl == 1 && !prot(bp, a)), "R5 array permit", a_ok, (wl == 1 && !prot(bp, a)));
              chk(s_ok == (wl == 1 && !(we == 1 && wp == 0)), "R6 status permit", s_ok, (wl == 1 && !(we == 1 && wp == 0)));
            end
            if (a_ok !== 1'bx) begin
              req_a = 11'h7FF; #1;
              chk(a_ok == (wl == 1 && bp == 0), "R5 top address", a_ok, (wl == 1 && bp == 0));
            end
          end
        end
      end
    end

    // R6 hardware protection blocks status write
    wp_n = 1'b1;
    cmd(8'h06);
    wp_n = 1'b0;
    wrsr(8'h00);
    chk(busy == 0, "R6 hw protect no cycle", busy, 0);
    rdsr_chk(8'h8E, "R6 hw protect kept");
    wp_n = 1'b1;
    wrsr(8'h00); wait_idle();
    rdsr_chk(8'h00, "R6 unprotected write");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule